// File: doc/BRIEF.md
# Windowed Register File

This block is a register file for a processor whose instructions carry only 3-bit register operands. It still reaches more registers than a 3-bit field can name. The physical registers are grouped into equal windows of eight. A window field in the machine status register selects the active window. Every operand index is then resolved inside that window: the window number forms the upper bits of the physical index, and the operand forms the lower three bits.

There are two read ports and one write port, and all three use window-relative indices. Two window-management operations are built in:

- A swap command takes a window number counted from one. From the next cycle on, that window becomes the active one.
- A cross-window move copies a register of the active window to any physical register. The destination is given by its full physical index. The move does not change the active window.

The machine status register can be read and fully written, so software can save and restore the active window.

Read data is registered: the value appears on the clock edge after the index is presented. A write or move that lands in the same cycle on the register being read is passed straight through to the read port.

Top module: `winreg_file`

## Requirements
- R1: Synchronous reset clears every register, both read outputs and the status register to zero. Window field 0 is window #1.
- R2: An operand index i in active window w selects physical register w*8+i. With 4 windows, the window field is status bits [1:0].
- R3: A valid swap with immediate k (1..NUM_WIN) sets the window field to k-1 at the next edge. Reads and writes in the same cycle as the swap still use the previous window.
- R4: A swap immediate of 0 or greater than NUM_WIN leaves the status register unchanged.
- R5: Read data for an index shows up only after the next rising clock edge. Before that edge, the output keeps its previous value.
- R6: A read of the register being written in the same cycle returns the new write data.
- R7: A move copies the value that its source register, in the active window, held at the start of the cycle into the physical destination. The active window is left unchanged.
- R8: When a write and a move target the same physical register in one cycle, the write data is stored. A read of a move destination in the same cycle returns the moved value.
- R9: A status register write replaces the whole register, window field included, at the next edge. It takes priority over a swap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rda_idx | input | 3 | Read port A operand index (window-relative) |
| rdb_idx | input | 3 | Read port B operand index (window-relative) |
| rda_data | output | DATA_W | Registered read data, port A |
| rdb_data | output | DATA_W | Registered read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write operand index (window-relative) |
| wr_data | input | DATA_W | Write data |
| mv_en | input | 1 | Cross-window move enable |
| mv_dst | input | PHYS_W | Move destination, full physical index |
| mv_src | input | 3 | Move source, window-relative index |
| swap_en | input | 1 | Swap command enable |
| swap_win | input | WIN_W+1 | Swap immediate, window number counted from 1 |
| msr_we | input | 1 | Status register write enable |
| msr_wdata | input | MSR_W | Status register write data |
| msr_rdata | output | MSR_W | Status register contents |

## Verification
The bench builds the block with NUM_WIN=4 and DATA_W=16, so the window field is two bits wide and the swap immediate three bits. This setting exercises swaps to windows #3 and #4. It also reaches the two out-of-range cases: immediate zero, and immediates 5 to 7 above the window count. With 32 physical registers, a move can land in a window other than the active one. The effect of that move is observed only after a later swap.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  // A swap immediate counts windows from one; zero and anything past the count are rejected.
  function automatic logic imm_in_range(input int unsigned imm, input int unsigned nwin);
    return (imm != 0) && (imm <= nwin);
  endfunction
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
  parameter int WIN_W = 1,
  parameter int OPW   = 3
) (
  input  logic [WIN_W-1:0]     win,
  input  logic [OPW-1:0]       idx,
  output logic [WIN_W+OPW-1:0] phys
);
  // Window number occupies the upper bits of the physical index.
  assign phys = {win, idx};
endmodule

// File: rtl/wrf_msr.sv
module wrf_msr #(
  parameter int MSR_W   = 8,
  parameter int WIN_W   = 1,
  parameter int NUM_WIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_en,
  input  logic [WIN_W:0]   swap_win,
  input  logic             we,
  input  logic [MSR_W-1:0] wdata,
  output logic [MSR_W-1:0] msr_q,
  output logic [WIN_W-1:0] win
);
  import wrf_pkg::*;

  localparam logic [WIN_W:0] ONE = {{WIN_W{1'b0}}, 1'b1};

  logic           swap_ok;
  logic [WIN_W:0] target;

  assign swap_ok = swap_en && imm_in_range(32'(swap_win), NUM_WIN);
  assign target  = swap_win - ONE;
  assign win     = msr_q[WIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q <= '0;
    end else if (we) begin
      msr_q <= wdata;
    end else if (swap_ok) begin
      msr_q[WIN_W-1:0] <= target[WIN_W-1:0];
    end
  end
endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
  parameter int DATA_W = 16,
  parameter int NREGS  = 16,
  parameter int PHYS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mv_en,
  input  logic [PHYS_W-1:0] mv_dst,
  input  logic [PHYS_W-1:0] mv_src,
  input  logic [PHYS_W-1:0] rda_addr,
  input  logic [PHYS_W-1:0] rdb_addr,
  output logic [DATA_W-1:0] rda_q,
  output logic [DATA_W-1:0] rdb_q
);
  logic [DATA_W-1:0] regs [NREGS];
  logic [DATA_W-1:0] nxt  [NREGS];
  logic [DATA_W-1:0] mv_val;

  // The move carries the value held before this edge.
  assign mv_val = regs[mv_src];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_comb begin
      if (wr_en && wr_addr == PHYS_W'(i))
        nxt[i] = wr_data;
      else if (mv_en && mv_dst == PHYS_W'(i))
        nxt[i] = mv_val;
      else
        nxt[i] = regs[i];
    end

    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else     regs[i] <= nxt[i];
    end
  end

  // Reading the next-state value gives write-through for writes and moves alike.
  always_ff @(posedge clk) begin
    if (rst) begin
      rda_q <= '0;
      rdb_q <= '0;
    end else begin
      rda_q <= nxt[rda_addr];
      rdb_q <= nxt[rdb_addr];
    end
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int DATA_W   = 16,
  parameter int NUM_WIN  = 2,
  parameter int WIN_REGS = 8,
  parameter int MSR_W    = 8,
  localparam int OPW     = $clog2(WIN_REGS),
  localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int NREGS   = NUM_WIN * WIN_REGS,
  localparam int PHYS_W  = WIN_W + OPW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPW-1:0]    rda_idx,
  input  logic [OPW-1:0]    rdb_idx,
  output logic [DATA_W-1:0] rda_data,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              wr_en,
  input  logic [OPW-1:0]    wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mv_en,
  input  logic [PHYS_W-1:0] mv_dst,
  input  logic [OPW-1:0]    mv_src,
  input  logic              swap_en,
  input  logic [WIN_W:0]    swap_win,
  input  logic              msr_we,
  input  logic [MSR_W-1:0]  msr_wdata,
  output logic [MSR_W-1:0]  msr_rdata
);
  logic [WIN_W-1:0]  cur_win;
  logic [PHYS_W-1:0] pa_a, pa_b, pa_w, pa_m;

  wrf_msr #(.MSR_W(MSR_W), .WIN_W(WIN_W), .NUM_WIN(NUM_WIN)) u_msr (
    .clk(clk), .rst(rst), .swap_en(swap_en), .swap_win(swap_win),
    .we(msr_we), .wdata(msr_wdata), .msr_q(msr_rdata), .win(cur_win)
  );

  wrf_xlate #(.WIN_W(WIN_W), .OPW(OPW)) u_xa (.win(cur_win), .idx(rda_idx), .phys(pa_a));
  wrf_xlate #(.WIN_W(WIN_W), .OPW(OPW)) u_xb (.win(cur_win), .idx(rdb_idx), .phys(pa_b));
  wrf_xlate #(.WIN_W(WIN_W), .OPW(OPW)) u_xw (.win(cur_win), .idx(wr_idx),  .phys(pa_w));
  wrf_xlate #(.WIN_W(WIN_W), .OPW(OPW)) u_xm (.win(cur_win), .idx(mv_src),  .phys(pa_m));

  wrf_bank #(.DATA_W(DATA_W), .NREGS(NREGS), .PHYS_W(PHYS_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(pa_w), .wr_data(wr_data),
    .mv_en(mv_en), .mv_dst(mv_dst), .mv_src(pa_m),
    .rda_addr(pa_a), .rdb_addr(pa_b),
    .rda_q(rda_data), .rdb_q(rdb_data)
  );
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int DATA_W  = 16,
  parameter int NUM_WIN = 2,
  parameter int MSR_W   = 8,
  parameter int OPW     = 3,
  parameter int WIN_W   = 1,
  parameter int PHYS_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [OPW-1:0]    rda_idx,
  input logic [DATA_W-1:0] rda_data,
  input logic [DATA_W-1:0] rdb_data,
  input logic              wr_en,
  input logic [OPW-1:0]    wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              swap_en,
  input logic [WIN_W:0]    swap_win,
  input logic              msr_we,
  input logic [MSR_W-1:0]  msr_wdata,
  input logic [MSR_W-1:0]  msr_rdata
);
  localparam logic [WIN_W:0] ONE = {{WIN_W{1'b0}}, 1'b1};
  localparam logic [WIN_W:0] TOP = (WIN_W+1)'(NUM_WIN);

  logic [WIN_W:0] want;
  logic           good_imm;
  assign want     = swap_win - ONE;
  assign good_imm = (swap_win != '0) && (swap_win <= TOP);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (rda_data == '0 && rdb_data == '0 && msr_rdata == '0));

  a_r3_swap_selects: assert property (@(posedge clk) disable iff (rst)
    (swap_en && !msr_we && good_imm) |=> msr_rdata[WIN_W-1:0] == $past(want[WIN_W-1:0]));

  a_r4_bad_swap_ignored: assert property (@(posedge clk) disable iff (rst)
    (swap_en && !msr_we && !good_imm) |=> $stable(msr_rdata));

  a_r6_write_through: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rda_idx == wr_idx) |=> rda_data == $past(wr_data));

  a_r9_msr_write: assert property (@(posedge clk) disable iff (rst)
    msr_we |=> msr_rdata == $past(msr_wdata));

  a_r9_msr_hold: assert property (@(posedge clk) disable iff (rst)
    (!msr_we && !swap_en) |=> $stable(msr_rdata));
endmodule

bind winreg_file wrf_checker #(
  .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .MSR_W(MSR_W),
  .OPW(OPW), .WIN_W(WIN_W), .PHYS_W(PHYS_W)
) u_wrf_checker (
  .clk(clk), .rst(rst), .rda_idx(rda_idx), .rda_data(rda_data), .rdb_data(rdb_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .swap_en(swap_en), .swap_win(swap_win),
  .msr_we(msr_we), .msr_wdata(msr_wdata), .msr_rdata(msr_rdata)
);

// File: tb/winreg_file_bench.sv
module winreg_file_bench;
  localparam int CLK_P = 10;
  localparam int DW = 16;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  rda_idx, rdb_idx, wr_idx, mv_src, swap_win;
  logic [DW-1:0] rda_data, rdb_data, wr_data;
  logic wr_en, mv_en, swap_en, msr_we;
  logic [4:0] mv_dst;
  logic [7:0] msr_wdata, msr_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  winreg_file #(.DATA_W(DW), .NUM_WIN(NW), .WIN_REGS(8), .MSR_W(8)) u_winreg_file (
    .clk(clk), .rst(rst), .rda_idx(rda_idx), .rdb_idx(rdb_idx),
    .rda_data(rda_data), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mv_en(mv_en), .mv_dst(mv_dst), .mv_src(mv_src),
    .swap_en(swap_en), .swap_win(swap_win),
    .msr_we(msr_we), .msr_wdata(msr_wdata), .msr_rdata(msr_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  wi;
    logic [15:0] wd;
    logic [2:0]  ra;
    logic [2:0]  rb;
    logic        se;
    logic [2:0]  sw;
    logic [15:0] ea;
    logic [15:0] eb;
    logic [1:0]  ew;
  } vec_t;

  // One vector per cycle; expectations are the values after that cycle's edge.
  localparam vec_t VT [10] = '{
    '{1'b1, 3'd1, 16'h1111, 3'd1, 3'd2, 1'b0, 3'd0, 16'h1111, 16'h0000, 2'd0},
    '{1'b1, 3'd2, 16'h2222, 3'd1, 3'd2, 1'b1, 3'd2, 16'h1111, 16'h2222, 2'd1},
    '{1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 1'b0, 3'd0, 16'h0000, 16'h0000, 2'd1},
    '{1'b1, 3'd1, 16'h9999, 3'd1, 3'd1, 1'b0, 3'd0, 16'h9999, 16'h9999, 2'd1},
    '{1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 1'b1, 3'd4, 16'h9999, 16'h0000, 2'd3},
    '{1'b1, 3'd7, 16'h7777, 3'd7, 3'd1, 1'b0, 3'd0, 16'h7777, 16'h0000, 2'd3},
    '{1'b0, 3'd0, 16'h0000, 3'd7, 3'd1, 1'b1, 3'd0, 16'h7777, 16'h0000, 2'd3},
    '{1'b0, 3'd0, 16'h0000, 3'd7, 3'd1, 1'b1, 3'd5, 16'h7777, 16'h0000, 2'd3},
    '{1'b0, 3'd0, 16'h0000, 3'd7, 3'd1, 1'b1, 3'd1, 16'h7777, 16'h0000, 2'd0},
    '{1'b0, 3'd0, 16'h0000, 3'd1, 3'd2, 1'b0, 3'd0, 16'h1111, 16'h2222, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = 0; wr_data = 0; mv_en = 0; mv_dst = 0; mv_src = 0;
    swap_en = 0; swap_win = 0; msr_we = 0; msr_wdata = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    idle();
    rda_idx = 0; rdb_idx = 5;
    rst = 1;
    step(); step();
    // R1: reset state
    chk("R1 rda", 32'(rda_data), 0);
    chk("R1 rdb", 32'(rdb_data), 0);
    chk("R1 msr", 32'(msr_rdata), 0);
    rst = 0;
    step();

    // Table walk: R2, R3, R4, R6
    for (int i = 0; i < 10; i++) begin
      idle();
      wr_en = VT[i].we; wr_idx = VT[i].wi; wr_data = VT[i].wd;
      rda_idx = VT[i].ra; rdb_idx = VT[i].rb;
      swap_en = VT[i].se; swap_win = VT[i].sw;
      step();
      chk($sformatf("R2/R6 vec%0d rda", i), 32'(rda_data), 32'(VT[i].ea));
      chk($sformatf("R2/R6 vec%0d rdb", i), 32'(rdb_data), 32'(VT[i].eb));
      chk($sformatf("R3/R4 vec%0d win", i), 32'(msr_rdata[1:0]), 32'(VT[i].ew));
    end
    idle();

    // R5: output holds until the edge
    rda_idx = 2;
    #2;
    chk("R5 before edge", 32'(rda_data), 32'h1111);
    step();
    chk("R5 after edge", 32'(rda_data), 32'h2222);

    // R7: move into window #2 register 5 (physical 13), active window stays
    mv_en = 1; mv_src = 1; mv_dst = 5'd13;
    step();
    chk("R7 window unchanged", 32'(msr_rdata[1:0]), 0);
    idle(); swap_en = 1; swap_win = 2;
    step();
    idle(); rda_idx = 5;
    step();
    chk("R7 moved value", 32'(rda_data), 32'h1111);

    // R7: move source takes pre-edge value
    wr_en = 1; wr_idx = 3; wr_data = 16'h3333;
    step();
    idle(); wr_en = 1; wr_idx = 3; wr_data = 16'hAAAA; mv_en = 1; mv_src = 3; mv_dst = 5'd0; rda_idx = 3;
    step();
    chk("R6 write-through", 32'(rda_data), 32'hAAAA);
    idle(); swap_en = 1; swap_win = 1;
    step();
    idle(); rda_idx = 0;
    step();
    chk("R7 old source value", 32'(rda_data), 32'h3333);

    // R8: write beats move on the same destination; move bypass
    wr_en = 1; wr_idx = 4; wr_data = 16'h4444; mv_en = 1; mv_src = 0; mv_dst = 5'd4; rda_idx = 4;
    step();
    chk("R8 same-cycle", 32'(rda_data), 32'h4444);
    idle(); rda_idx = 4;
    step();
    chk("R8 stored", 32'(rda_data), 32'h4444);
    mv_en = 1; mv_src = 0; mv_dst = 5'd5; rdb_idx = 5;
    step();
    chk("R8 move bypass", 32'(rdb_data), 32'h3333);

    // R9: status write wins over swap
    idle(); msr_we = 1; msr_wdata = 8'hA6; swap_en = 1; swap_win = 1;
    step();
    chk("R9 msr write", 32'(msr_rdata), 32'hA6);
    idle(); rda_idx = 1;
    step();
    chk("R9 window #3 empty", 32'(rda_data), 0);
    wr_en = 1; wr_idx = 1; wr_data = 16'h5555;
    step();
    idle(); msr_we = 1; msr_wdata = 8'h00;
    step();
    chk("R9 msr restore", 32'(msr_rdata), 0);
    idle(); rda_idx = 1;
    step();
    chk("R9 back in window #1", 32'(rda_data), 32'h1111);

    // R1: reset clears stored registers
    rst = 1;
    step();
    chk("R1 msr after reset", 32'(msr_rdata), 0);
    rst = 0; rda_idx = 1; rdb_idx = 2;
    step();
    chk("R1 reg cleared a", 32'(rda_data), 0);
    chk("R1 reg cleared b", 32'(rdb_data), 0);

    wrap_up();
  end
endmodule